// File: doc/BRIEF.md
# Dual-Pipe Instruction Pairing Issue Logic

This block sits after decode in an in-order core that has two integer pipes, called U and V. Each cycle it looks at the two oldest decoded instructions. The older one is the lead and the younger one is the trail. The block decides whether the lead issues alone into U, whether both issue together (lead in U, trail in V), or whether nothing issues because earlier work still occupies the pipes.

Every instruction is sorted into a pairability class from its kind code, its memory-access class, a prefix flag, an immediate-plus-displacement flag and a constant-operand flag. The classes are: either pipe (uv), U only (pu), V only (pv) and not pairable (np). An occupancy counter blocks issue while multi-cycle work holds both pipes. A second counter blocks pairing while a call holds the V pipe.

A memory-ordering hold delays a load that would pair with a load-execute-store instruction. That load starts in V during the last cycle of the store instruction. The environment counts one consumed instruction per asserted issue strobe and shifts the trail into the lead slot accordingly.

Top module: `pairq_issue`

## Requirements
- R1: While reset is low, and in the first cycle after it, the occupancy counter, the call window and the memory-ordering hold are all cleared. No issue strobe is high while the lead is invalid, and a valid lead issues in the first cycle after reset.
- R2: Kind codes are 0 simple ALU/move/compare/test/address/inc-dec, 1 push/pop, 2 conditional branch, 3 call, 4 shift, 5 rotate, 6 multiply, 7 string. Memory codes are 0 none, 1 load, 2 store, 3 load-and-store. Kinds 0 and 1 are class uv, except kind 1 with memory code 3, which is np. A set prefix flag turns uv into pu.
- R3: An instruction whose immediate-plus-displacement flag is set is class np, whatever its kind.
- R4: A branch, and a call with its constant flag set, are class pv. A shift or a rotate with its constant flag set is class pu. Calls, shifts and rotates without that flag are np, and so are kinds 6 to 15.
- R5: A pair issues (issue_u and issue_v both high) only when the trail is valid, the lead is uv or pu, and the trail is uv or pv. Otherwise a valid lead issues alone on issue_u. issue_v never rises without issue_u, except in the deferred start of R8.
- R6: A high dep_hold forces the lead to issue alone. The exception is a push/pop lead with a push/pop or call trail, which still pairs.
- R7: A group that issues keeps further issue blocked for the longest occupancy among its members, minus one cycle. Occupancy is 1 cycle for memory codes 0 and 2, 2 cycles for code 1 and 3 cycles for code 3.
- R8: If a lead with memory code 3 would pair with a trail of memory code 1 or 3, the lead issues alone. The next lead then starts on issue_v alone in the third cycle of the first instruction. If no lead is valid in that cycle, the hold lapses.
- R9: A multiply blocks all issue for 11 cycles in total and a string operation for 12.
- R10: An issued call blocks pairing for 10 cycles (its own and the next nine). Lone U issue continues during that window.
- R11: stall is high exactly when the lead is valid and neither strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_valid | input | 1 | Lead slot holds an instruction |
| lead_kind | input | 4 | Lead kind code (R2) |
| lead_mem | input | 2 | Lead memory-access code (R2) |
| lead_pfx | input | 1 | Lead carries an escape, operand-size or repeat prefix |
| lead_immdisp | input | 1 | Lead has both an immediate and a displacement |
| lead_cnst | input | 1 | Lead shift count constant, rotate by one, or call target constant |
| trail_valid | input | 1 | Trail slot holds an instruction |
| trail_kind | input | 4 | Trail kind code |
| trail_mem | input | 2 | Trail memory-access code |
| trail_pfx | input | 1 | Trail prefix flag |
| trail_immdisp | input | 1 | Trail immediate-plus-displacement flag |
| trail_cnst | input | 1 | Trail constant-operand flag |
| dep_hold | input | 1 | Trail depends on the lead's result |
| issue_u | output | 1 | An instruction starts in the U pipe |
| issue_v | output | 1 | An instruction starts in the V pipe |
| stall | output | 1 | Lead valid but nothing issued |

## Verification
Every pairing of classes is tried: uv-uv, pu-uv, uv-pu, uv-pv, pv-uv, np on either side, an invalid trail and an invalid lead. Each one shows whether the class table and the legality rule agree on pair versus lone issue. Occupancy is probed with register, load and load-store groups, with a trail that is longer than its lead, and with multiply and string runs. Comparing stall counts separates per-member occupancy from per-group occupancy. The store-pending hold is driven both with a waiting load and with an empty slot, and the call window is opened both by a normal pair and by a dependent push-call pair. These runs separate the V-only deferred start, the lapse of the hold and the stack-forwarding exception to dep_hold. Resets in the middle of a multiply and of a call window show that all state clears.

// File: rtl/pairq_pkg.sv
package pairq_pkg;
  localparam int KIND_W = 4;

  localparam logic [KIND_W-1:0] K_ALU    = 4'd0;
  localparam logic [KIND_W-1:0] K_STACK  = 4'd1;
  localparam logic [KIND_W-1:0] K_BRANCH = 4'd2;
  localparam logic [KIND_W-1:0] K_CALL   = 4'd3;
  localparam logic [KIND_W-1:0] K_SHIFT  = 4'd4;
  localparam logic [KIND_W-1:0] K_ROTATE = 4'd5;
  localparam logic [KIND_W-1:0] K_MUL    = 4'd6;
  localparam logic [KIND_W-1:0] K_STRING = 4'd7;

  typedef enum logic [1:0] {
    MEM_NONE  = 2'd0,
    MEM_LOAD  = 2'd1,
    MEM_STORE = 2'd2,
    MEM_BOTH  = 2'd3
  } mem_e;

  typedef enum logic [1:0] {PC_UV, PC_PU, PC_PV, PC_NP} pclass_e;

  typedef struct packed {
    logic              valid;
    logic [KIND_W-1:0] kind;
    mem_e              mem;
    logic              pfx;
    logic              immdisp;
    logic              cnst;
  } slot_t;

  function automatic pclass_e classify(input slot_t s);
    pclass_e c;
    if (s.immdisp) c = PC_NP;
    else begin
      case (s.kind)
        K_ALU:            c = s.pfx ? PC_PU : PC_UV;
        K_STACK:          c = (s.mem == MEM_BOTH) ? PC_NP : (s.pfx ? PC_PU : PC_UV);
        K_BRANCH:         c = PC_PV;
        K_CALL:           c = s.cnst ? PC_PV : PC_NP;
        K_SHIFT, K_ROTATE: c = s.cnst ? PC_PU : PC_NP;
        default:          c = PC_NP;
      endcase
    end
    return c;
  endfunction

  function automatic logic fits_u(input pclass_e c);
    return (c == PC_UV) || (c == PC_PU);
  endfunction

  function automatic logic fits_v(input pclass_e c);
    return (c == PC_UV) || (c == PC_PV);
  endfunction

  function automatic logic reads_mem(input slot_t s);
    return (s.mem == MEM_LOAD) || (s.mem == MEM_BOTH);
  endfunction

  // Cycles that an instruction keeps both pipes from taking new work.
  function automatic int unsigned occupancy(input slot_t s, input int unsigned mul_c,
                                            input int unsigned str_c);
    int unsigned n;
    if (s.kind == K_MUL)         n = mul_c;
    else if (s.kind == K_STRING) n = str_c;
    else if (s.mem == MEM_BOTH)  n = 3;
    else if (s.mem == MEM_LOAD)  n = 2;
    else                         n = 1;
    return n;
  endfunction

  function automatic logic stack_forward(input slot_t ld, input slot_t tr);
    return (ld.kind == K_STACK) && ((tr.kind == K_STACK) || (tr.kind == K_CALL));
  endfunction
endpackage

// File: rtl/pairq_classify.sv
module pairq_classify
  import pairq_pkg::*;
(
  input  slot_t   s,
  output pclass_e cls
);
  always_comb cls = classify(s);
endmodule

// File: rtl/pairq_decide.sv
module pairq_decide
  import pairq_pkg::*;
(
  input  slot_t   ld,
  input  slot_t   tr,
  input  pclass_e cls_ld,
  input  pclass_e cls_tr,
  input  logic    dep_hold,
  input  logic    v_free,
  output logic    pair_ok,
  output logic    order_hold,
  output logic    fwd_ok
);
  always_comb begin
    fwd_ok     = stack_forward(ld, tr);
    pair_ok    = tr.valid && fits_u(cls_ld) && fits_v(cls_tr) && v_free &&
                 (!dep_hold || fwd_ok);
    order_hold = (ld.mem == MEM_BOTH) && reads_mem(tr);
  end
endmodule

// File: rtl/pairq_occupancy.sv
module pairq_occupancy
  import pairq_pkg::*;
#(
  parameter int MUL_CYC   = 11,
  parameter int STR_CYC   = 12,
  parameter int CALL_VCYC = 10,
  parameter int CNT_W     = 4,
  parameter int VCNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t             ld,
  input  slot_t             tr,
  input  logic              issue_u,
  input  logic              pair_go,
  input  logic              defer_go,
  input  logic              hold_set,
  output logic [CNT_W-1:0]  busy_q,
  output logic [VCNT_W-1:0] vbusy_q,
  output logic              hold_q
);
  logic [CNT_W-1:0] span_ld, span_tr, span_grp;
  logic             call_start;

  always_comb begin
    span_ld    = CNT_W'(occupancy(ld, MUL_CYC, STR_CYC) - 1);
    span_tr    = CNT_W'(occupancy(tr, MUL_CYC, STR_CYC) - 1);
    span_grp   = (pair_go && (span_tr > span_ld)) ? span_tr : span_ld;
    call_start = ((issue_u || defer_go) && (ld.kind == K_CALL)) ||
                 (pair_go && (tr.kind == K_CALL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      vbusy_q <= '0;
      hold_q  <= 1'b0;
    end else begin
      if (issue_u)            busy_q <= span_grp;
      else if (defer_go)      busy_q <= span_ld;
      else if (busy_q != '0)  busy_q <= busy_q - CNT_W'(1);

      if (issue_u)                 hold_q <= hold_set;
      else if (busy_q <= CNT_W'(1)) hold_q <= 1'b0;

      if (call_start)          vbusy_q <= VCNT_W'(CALL_VCYC - 1);
      else if (vbusy_q != '0)  vbusy_q <= vbusy_q - VCNT_W'(1);
    end
  end

  AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q != '0 && !defer_go) |=> (busy_q == $past(busy_q) - CNT_W'(1)))
    else $error("occupancy did not count down"); // R7
endmodule

// File: rtl/pairq_issue.sv
module pairq_issue
  import pairq_pkg::*;
#(
  parameter int MUL_CYC   = 11,
  parameter int STR_CYC   = 12,
  parameter int CALL_VCYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lead_valid,
  input  logic [3:0] lead_kind,
  input  logic [1:0] lead_mem,
  input  logic       lead_pfx,
  input  logic       lead_immdisp,
  input  logic       lead_cnst,
  input  logic       trail_valid,
  input  logic [3:0] trail_kind,
  input  logic [1:0] trail_mem,
  input  logic       trail_pfx,
  input  logic       trail_immdisp,
  input  logic       trail_cnst,
  input  logic       dep_hold,
  output logic       issue_u,
  output logic       issue_v,
  output logic       stall
);
  localparam int NSLOT   = 2;
  localparam int LONGEST = (MUL_CYC > STR_CYC) ? MUL_CYC : STR_CYC;
  localparam int OCC_MAX = (LONGEST > 3) ? LONGEST : 3;
  localparam int CNT_W   = $clog2(OCC_MAX + 1);
  localparam int VCNT_W  = $clog2(CALL_VCYC + 1);

  slot_t   slots [NSLOT];
  pclass_e cls   [NSLOT];

  assign slots[0] = {lead_valid, lead_kind, lead_mem, lead_pfx, lead_immdisp, lead_cnst};
  assign slots[1] = {trail_valid, trail_kind, trail_mem, trail_pfx, trail_immdisp, trail_cnst};

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_cls
    pairq_classify u_cls (.s(slots[gi]), .cls(cls[gi]));
  end

  logic              pair_ok, order_hold, fwd_ok;
  logic              pair_go, defer_go, hold_set;
  logic [CNT_W-1:0]  busy_q;
  logic [VCNT_W-1:0] vbusy_q;
  logic              hold_q;

  pairq_decide u_decide (
    .ld(slots[0]), .tr(slots[1]), .cls_ld(cls[0]), .cls_tr(cls[1]),
    .dep_hold(dep_hold), .v_free(vbusy_q == '0),
    .pair_ok(pair_ok), .order_hold(order_hold), .fwd_ok(fwd_ok)
  );

  always_comb begin
    issue_u  = lead_valid && (busy_q == '0);
    hold_set = issue_u && pair_ok && order_hold;
    pair_go  = issue_u && pair_ok && !order_hold;
    defer_go = lead_valid && hold_q && (busy_q == CNT_W'(1));
    issue_v  = pair_go || defer_go;
    stall    = lead_valid && !issue_u && !issue_v;
  end

  pairq_occupancy #(
    .MUL_CYC(MUL_CYC), .STR_CYC(STR_CYC), .CALL_VCYC(CALL_VCYC),
    .CNT_W(CNT_W), .VCNT_W(VCNT_W)
  ) u_occ (
    .clk(clk), .rst_n(rst_n), .ld(slots[0]), .tr(slots[1]),
    .issue_u(issue_u), .pair_go(pair_go), .defer_go(defer_go), .hold_set(hold_set),
    .busy_q(busy_q), .vbusy_q(vbusy_q), .hold_q(hold_q)
  );

  AST_V_WITH_U: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_v && !hold_q) |-> issue_u)
    else $error("V issued without U"); // R5
  AST_DEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dep_hold && !fwd_ok && issue_u) |-> !issue_v)
    else $error("dependent pair issued"); // R6
  AST_CALL_NOPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (vbusy_q != '0) |-> !(issue_u && issue_v))
    else $error("pair inside call window"); // R10
  AST_HOLD_FROM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(issue_u && !issue_v))
    else $error("hold without lone lead"); // R8
  AST_MUL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_u && lead_kind == K_MUL) |-> (busy_q == CNT_W'(MUL_CYC - 1)))
    else $error("multiply span wrong"); // R9
  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (busy_q != '0))
    else $error("stall while idle"); // R11
endmodule

// File: tb/tb_pairq_issue.sv
module tb_pairq_issue;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic v; logic [3:0] k; logic [1:0] m; logic p; logic i; logic c;
  } ins_t;

  localparam logic [3:0] KA = 4'd0, KS = 4'd1, KB = 4'd2, KC = 4'd3,
                         KSH = 4'd4, KR = 4'd5, KM = 4'd6, KST = 4'd7;
  localparam logic [1:0] MN = 2'd0, ML = 2'd1, MS = 2'd2, MB = 2'd3;
  localparam logic [2:0] IDLE = 3'b000, PAIR = 3'b110, SOLO = 3'b100,
                         STALL = 3'b001, DEFV = 3'b010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lead_valid = 0, lead_pfx = 0, lead_immdisp = 0, lead_cnst = 0;
  logic [3:0] lead_kind = 0;
  logic [1:0] lead_mem = 0;
  logic trail_valid = 0, trail_pfx = 0, trail_immdisp = 0, trail_cnst = 0;
  logic [3:0] trail_kind = 0;
  logic [1:0] trail_mem = 0;
  logic dep_hold = 0;
  logic issue_u, issue_v, stall;

  int checks = 0, bad = 0;
  logic done = 1'b0;
  logic [2:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pairq_issue dut (.*);

  function automatic ins_t mk(logic [3:0] k, logic [1:0] m, logic p, logic i, logic c);
    return '{v: 1'b1, k: k, m: m, p: p, i: i, c: c};
  endfunction

  localparam ins_t NOP = '0;

  task automatic step(input ins_t l, input ins_t t, input logic dep,
                      input logic [2:0] e, input string tag);
    @(negedge clk); #1;
    {lead_valid, lead_kind, lead_mem, lead_pfx, lead_immdisp, lead_cnst} = l;
    {trail_valid, trail_kind, trail_mem, trail_pfx, trail_immdisp, trail_cnst} = t;
    dep_hold = dep;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic pulse_reset();
    @(negedge clk); #1;
    {lead_valid, trail_valid, dep_hold} = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  // monitor: compares each expected item away from the clock edge
  initial begin
    forever begin
      @(negedge clk); #3;
      if (exp_q.size() != 0) begin
        logic [2:0] e, got;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        got = {issue_u, issue_v, stall};
        checks++;
        if (got !== e) begin
          bad++;
          $display("FAIL %s: u/v/stall got %b expected %b", tg, got, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    ins_t alu, alup, alui, alul, alub, push, br, shc, shn, rc, rn, callc, calln, mul, str;
    alu   = mk(KA, MN, 0, 0, 0);
    alup  = mk(KA, MN, 1, 0, 0);
    alui  = mk(KA, MN, 0, 1, 0);
    alul  = mk(KA, ML, 0, 0, 0);
    alub  = mk(KA, MB, 0, 0, 0);
    push  = mk(KS, MS, 0, 0, 0);
    br    = mk(KB, MN, 0, 0, 0);
    shc   = mk(KSH, MN, 0, 0, 1);
    shn   = mk(KSH, MN, 0, 0, 0);
    rc    = mk(KR, MN, 0, 0, 1);
    rn    = mk(KR, MN, 0, 0, 0);
    callc = mk(KC, MN, 0, 0, 1);
    calln = mk(KC, MN, 0, 0, 0);
    mul   = mk(KM, MN, 0, 0, 0);
    str   = mk(KST, MN, 0, 0, 0);

    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    step(NOP, NOP, 0, IDLE, "R1 idle after reset");
    step(alu, alu, 0, PAIR, "R1 first lead issues at once");

    step(alu, alu, 0, PAIR, "R2 uv with uv");
    step(push, push, 0, PAIR, "R2 push with push");
    step(alup, alu, 0, PAIR, "R2 prefixed lead takes U");
    step(alu, alup, 0, SOLO, "R2 prefixed trail not in V");
    step(mk(KS, MB, 0, 0, 0), alu, 0, SOLO, "R2 stack load-store is np");
    step(STALL == 3'b001 ? alu : alu, alu, 0, STALL, "R7 np stack op occupancy");
    step(alu, alu, 0, STALL, "R7 np stack op occupancy 2");

    step(alui, alu, 0, SOLO, "R3 imm+disp lead");
    step(alu, alui, 0, SOLO, "R3 imm+disp trail");

    step(alu, br, 0, PAIR, "R4 branch in V");
    step(br, alu, 0, SOLO, "R4 branch cannot lead pair");
    step(shc, alu, 0, PAIR, "R4 const shift leads");
    step(shn, alu, 0, SOLO, "R4 variable shift np");
    step(alu, shc, 0, SOLO, "R4 const shift not in V");
    step(rc, alu, 0, PAIR, "R4 rotate by one leads");
    step(rn, alu, 0, SOLO, "R4 other rotate np");
    step(alu, calln, 0, SOLO, "R4 indirect call np");

    step(alu, NOP, 0, SOLO, "R5 no trail");
    step(NOP, alu, 0, IDLE, "R5 no lead no V");

    step(alu, alu, 1, SOLO, "R6 dependency splits");
    step(push, push, 1, PAIR, "R6 stack forward pairs");
    step(alu, push, 1, SOLO, "R6 no forward from alu");

    step(alul, alu, 0, PAIR, "R7 load pair");
    step(alu, alu, 0, STALL, "R7 load occupancy");
    step(alu, alu, 0, PAIR, "R7 after load");
    step(alu, alub, 0, PAIR, "R7 longer trail");
    step(alu, alu, 0, STALL, "R7 trail occupancy 1");
    step(alu, alu, 0, STALL, "R7 trail occupancy 2");
    step(alu, alu, 0, PAIR, "R7 after trail");

    step(alub, alul, 0, SOLO, "R8 ordering hold");
    step(alul, NOP, 0, STALL, "R8 held load waits");
    step(alul, NOP, 0, DEFV, "R8 deferred start in V");
    step(alu, alu, 0, STALL, "R8 deferred load occupancy");
    step(alu, alu, 0, PAIR, "R8 after deferred load");
    step(alub, alul, 0, SOLO, "R8 hold lapse setup");
    step(NOP, NOP, 0, IDLE, "R8 empty wait");
    step(NOP, NOP, 0, IDLE, "R8 empty last cycle");
    step(alu, alu, 0, PAIR, "R8 hold lapsed");

    step(mul, alu, 0, SOLO, "R9 multiply issues");
    for (int i = 0; i < 10; i++) step(alu, alu, 0, STALL, "R9 multiply blocks");
    step(alu, alu, 0, PAIR, "R9 after multiply");
    step(str, alu, 0, SOLO, "R9 string issues");
    for (int i = 0; i < 11; i++) step(alu, alu, 0, STALL, "R9 string blocks");
    step(alu, alu, 0, PAIR, "R9 after string");

    step(alu, callc, 0, PAIR, "R10 call pairs in V");
    for (int i = 0; i < 9; i++) step(alu, alu, 0, SOLO, "R10 call window single");
    step(alu, alu, 0, PAIR, "R10 window over");
    step(push, callc, 1, PAIR, "R6 push forwards to call");
    for (int i = 0; i < 9; i++) step(alu, alu, 0, SOLO, "R10 second window");
    step(alu, alu, 0, PAIR, "R10 second window over");

    step(mul, NOP, 0, SOLO, "R1 multiply before reset");
    step(alu, NOP, 0, STALL, "R11 stall reported");
    pulse_reset();
    step(alu, alu, 0, PAIR, "R1 reset clears occupancy");
    step(alu, callc, 0, PAIR, "R1 call before reset");
    pulse_reset();
    step(alu, alu, 0, PAIR, "R1 reset clears call window");
    step(alub, alul, 0, SOLO, "R1 hold before reset");
    pulse_reset();
    step(alul, NOP, 0, SOLO, "R1 reset clears hold");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule